// File: doc/BRIEF.md
# Dual-Clocking Result Word Serializer

This block holds one finished conversion result and sends it, most significant bit first, on a single serial data line. A one-cycle strobe captures the parallel word and pulls the active-low pending flag `rdy_n` low. The flag goes back high once the final bit has left. Readout starts when a result is pending and the active-low select is low. A select that is low while nothing is pending does nothing.

A static mode pin picks who owns the serial clock. In self-clocked mode the port makes its own clock from the system clock: one period high, one period low. The first data bit is placed on the line one period before the first rising edge. In follower mode the port tracks an externally driven clock, brought into the system-clock domain through two flops. It needs one rising edge of that clock before any falling edge counts as a shift. In both modes data changes only after a falling edge.

If select is released part way through a word, the bit in flight completes and both outputs float. The result stays pending, and the next selection carries on with the next unsent bit. The select input also passes through a two-flop synchronizer. The output enables stand for high impedance.

Top module: `res_serial_port`

## Requirements
- R1: While reset is applied and right after it, `sdo_oe` and `sck_oe` are 0 and `rdy_n` is 1.
- R2: A strobe taken while `rdy_n` is 1 captures `res_word` and makes `rdy_n` 0 after that edge. A strobe taken while `rdy_n` is 0 is ignored, and the word already held is the one sent.
- R3: Self-clocked mode (`clk_self` = 1) works as follows:
  - `sck_o` is high for exactly one system-clock period, then low for exactly one period.
  - Bits go out MSB first, each lasting two periods.
  - The MSB is driven one period before the first rising edge of `sck_o`.
- R4: Start latency in self-clocked mode:
  - If select is already low, output drives start on the first edge after the edge where `rdy_n` falls.
  - If a result is pending, output drives start on the third rising edge at which `cs_n` is sampled low.
- R5: `sdo` changes only on the system-clock edge that ends a high phase of `sck_o` (self-clocked), or the edge that acts on a detected falling edge of `sck_i` (follower).
- R6: In follower mode (`clk_self` = 0), falling edges of `sck_i` are ignored until a rising edge of `sck_i` has been seen since the selection started.
- R7: In follower mode, bits go out MSB first and advance on each accepted falling edge. After the falling edge that ends the last bit, `sdo_oe` is 0 and `rdy_n` is 1.
- R8: Early release of select behaves as follows:
  - The bit in progress finishes before `sdo_oe` and `sck_oe` drop. In self-clocked mode this means drives end right after a high phase of `sck_o`.
  - `rdy_n` stays 0.
  - The next selection resumes with the first unsent bit.
- R9: While `rdy_n` is 1, a low `cs_n` never enables either output.
- R10: In self-clocked mode, on the edge that ends the last high phase of `sck_o`, `sdo_oe` and `sck_oe` go to 0 and `rdy_n` goes to 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_self | input | 1 | Static mode: 1 = port drives the serial clock, 0 = follows `sck_i` |
| cs_n | input | 1 | Active-low select, asynchronous |
| res_stb | input | 1 | One-cycle strobe that captures `res_word` |
| res_word | input | WORD_W | Parallel conversion result |
| sck_i | input | 1 | External serial clock, asynchronous |
| sdo | output | 1 | Serial data |
| sdo_oe | output | 1 | Drive enable for `sdo` (0 = high impedance) |
| sck_o | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Drive enable for `sck_o` (0 = high impedance) |
| rdy_n | output | 1 | Low while a captured result is pending |

## Verification
A wrong bit index appears in `sdo` at the very next high phase of the serial clock. A received word differs from the loaded one within two system clocks of the fault, and every word value is swept in both modes for this reason. A stuck phase state shows up within one period as a serial clock high for two periods, or as drives that never release. A lost arming flag shows up as a shift on the unarmed falling edge in follower mode, seen one bit time later. Pending-flag faults show up as outputs enabled while nothing is pending, or as a word that restarts instead of resuming after an early release.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_M_PRE = 3'd1,
    ST_M_HI  = 3'd2,
    ST_M_LO  = 3'd3,
    ST_S_ACT = 3'd4
  } rsp_state_e;
endpackage

// File: rtl/rsp_rst_sync.sv
module rsp_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) stage_q <= 2'b00;
    else              stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/rsp_sync.sv
module rsp_sync #(
  parameter int               WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/rsp_ctrl.sv
module rsp_ctrl
  import rsp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_self,
  input  logic              cs_s,
  input  logic              sck_s,
  input  logic              load_stb,
  input  logic [WORD_W-1:0] load_word,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              rdy_n
);
  localparam int              IDX_W    = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  rsp_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] word_q;
  logic              rdy_n_q, rdy_n_d;
  logic              armed_q, armed_d;
  logic              sck_d_q;
  logic              sck_rise, sck_fall;
  logic              load_en;
  logic              shift_evt;

  assign sck_rise = sck_s & ~sck_d_q;
  assign sck_fall = ~sck_s & sck_d_q;
  assign load_en  = load_stb & rdy_n_q & (state_q == ST_IDLE);

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    rdy_n_d   = rdy_n_q;
    armed_d   = armed_q;
    shift_evt = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (load_en) begin
          idx_d   = LAST_IDX;
          rdy_n_d = 1'b0;
        end else if (!rdy_n_q && !cs_s) begin
          state_d = clk_self ? ST_M_PRE : ST_S_ACT;
          armed_d = 1'b0;
        end
      end
      ST_M_PRE, ST_M_LO: state_d = ST_M_HI;
      ST_M_HI: begin
        shift_evt = 1'b1;
        if (idx_q == '0) begin
          state_d = ST_IDLE;
          rdy_n_d = 1'b1;
        end else begin
          idx_d   = idx_q - 1'b1;
          state_d = cs_s ? ST_IDLE : ST_M_LO;
        end
      end
      ST_S_ACT: begin
        if (sck_rise) armed_d = 1'b1;
        if (armed_q && sck_fall) begin
          shift_evt = 1'b1;
          if (idx_q == '0) begin
            state_d = ST_IDLE;
            rdy_n_d = 1'b1;
          end else begin
            idx_d = idx_q - 1'b1;
            if (cs_s) state_d = ST_IDLE;
          end
        end else if (cs_s && !armed_q) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      rdy_n_q <= 1'b1;
      armed_q <= 1'b0;
      sck_d_q <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      rdy_n_q <= rdy_n_d;
      armed_q <= armed_d;
      sck_d_q <= sck_s;
    end
  end

  // word holding register, written only on an accepted strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (load_en) word_q <= load_word;
  end

  assign sdo    = word_q[idx_q];
  assign sdo_oe = (state_q != ST_IDLE);
  assign sck_o  = (state_q == ST_M_HI);
  assign sck_oe = (state_q == ST_M_PRE) || (state_q == ST_M_HI) || (state_q == ST_M_LO);
  assign rdy_n  = rdy_n_q;

  // R3: high phase of the generated clock lasts one period
  a_r3_high_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_M_HI) |=> (state_q != ST_M_HI));
  // R3: every low phase is followed by a high phase
  a_r3_low_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_M_PRE || state_q == ST_M_LO) |=> (state_q == ST_M_HI));
  // R5: no data change without a shift event
  a_r5_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !shift_evt) |=> (state_q == ST_IDLE || $stable(sdo)));
  // R6: an unarmed follower ignores falling edges
  a_r6_unarmed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_S_ACT && !armed_q) |=> $stable(idx_q));
  // R9: nothing pending, nothing starts
  a_r9_blackout: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && rdy_n_q) |=> (state_q == ST_IDLE));
  // R2: a held result is not overwritten
  a_r2_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_n_q) |=> $stable(word_q));
  // R7 / R10: pending flag clears only after the final bit
  a_r10_rdy_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_n_q) |-> (state_q == ST_IDLE && $past(idx_q) == '0));
  // R3: generated clock is only driven in self-clocked mode
  a_r3_sck_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !clk_self) |=> !sck_oe);
endmodule

// File: rtl/res_serial_port.sv
module res_serial_port #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_self,
  input  logic              cs_n,
  input  logic              res_stb,
  input  logic [WORD_W-1:0] res_word,
  input  logic              sck_i,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              rdy_n
);
  logic       rst_n_int;
  logic [1:0] async_in;
  logic [1:0] async_s;

  rsp_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  assign async_in = {cs_n, sck_i};

  rsp_sync #(.WIDTH(2), .RST_VAL(2'b10)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d     (async_in),
    .q     (async_s)
  );

  rsp_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .clk_self  (clk_self),
    .cs_s      (async_s[1]),
    .sck_s     (async_s[0]),
    .load_stb  (res_stb),
    .load_word (res_word),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .sck_o     (sck_o),
    .sck_oe    (sck_oe),
    .rdy_n     (rdy_n)
  );

  // R1: outputs idle while a result is absent and nothing is selected
  a_r1_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rdy_n && !sdo_oe) |=> (!sck_oe || !rdy_n));
endmodule

// File: tb/tb_res_serial_port.sv
module tb_res_serial_port;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         clk_self;
  logic         cs_n;
  logic         res_stb;
  logic [W-1:0] res_word;
  logic         sck_i;
  logic         sdo, sdo_oe, sck_o, sck_oe, rdy_n;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  res_serial_port #(.WORD_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .clk_self(clk_self), .cs_n(cs_n),
    .res_stb(res_stb), .res_word(res_word), .sck_i(sck_i),
    .sdo(sdo), .sdo_oe(sdo_oe), .sck_o(sck_o), .sck_oe(sck_oe), .rdy_n(rdy_n)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual cycles=%0d expected <= 100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(input logic [W-1:0] w);
    @(negedge clk);
    res_stb  = 1'b1;
    res_word = w;
    @(negedge clk);
    res_stb  = 1'b0;
    res_word = '0;
  endtask

  // self-clocked readout, called at the negedge where the preamble phase is visible
  task automatic m_read(input logic [W-1:0] w);
    int phase_err = 0;
    logic [W-1:0] rx = '0;
    if (!(sdo_oe && sck_oe && !sck_o && sdo == w[W-1])) phase_err++;
    for (int k = W - 1; k >= 0; k--) begin
      @(negedge clk);
      if (!(sck_o && sck_oe && sdo_oe && sdo == w[k])) phase_err++;
      rx = {rx[W-2:0], sdo};
      if (k > 0) begin
        @(negedge clk);
        if (!(!sck_o && sck_oe && sdo_oe && sdo == w[k-1])) phase_err++;
      end
    end
    @(negedge clk);
    chk(phase_err == 0, "R3 clock phases and bit placement", phase_err, 0);
    chk(rx == w, "R3 received word", int'(rx), int'(w));
    chk(!sdo_oe && !sck_oe && rdy_n, "R10 release after last high phase",
        {sdo_oe, sck_oe, rdy_n}, 3'b001);
  endtask

  // self-clocked with select already low: load then read
  task automatic m_word(input logic [W-1:0] w);
    load(w);
    chk(rdy_n == 1'b0 && !sdo_oe, "R2 capture", {rdy_n, sdo_oe}, 2'b00);
    @(negedge clk);
    chk(sdo_oe && sdo == w[W-1], "R4 MSB one clock after ready", {sdo_oe, sdo}, {1'b1, w[W-1]});
    m_read(w);
  endtask

  // follower readout
  task automatic s_word(input logic [W-1:0] w);
    int err = 0;
    logic [W-1:0] rx = '0;
    logic first;
    sck_i = 1'b1;
    wait_n(5);
    load(w);
    wait_n(4);
    chk(sdo_oe && !sck_oe && sdo == w[W-1], "R7 follower start MSB",
        {sdo_oe, sck_oe, sdo}, {2'b10, w[W-1]});
    sck_i = 1'b0;
    wait_n(5);
    chk(sdo_oe && sdo == w[W-1], "R6 unarmed falling edge ignored", sdo, w[W-1]);
    for (int k = W - 1; k >= 0; k--) begin
      sck_i = 1'b1;
      wait_n(1);
      first = sdo;
      wait_n(4);
      if (sdo != first || sdo != w[k] || !sdo_oe) err++;
      rx = {rx[W-2:0], sdo};
      sck_i = 1'b0;
      wait_n(5);
    end
    chk(err == 0, "R5 follower data stable in high phase", err, 0);
    chk(rx == w, "R7 follower received word", int'(rx), int'(w));
    chk(!sdo_oe && rdy_n, "R7 release after last falling edge", {sdo_oe, rdy_n}, 2'b01);
  endtask

  initial begin
    rst_n    = 1'b0;
    clk_self = 1'b1;
    cs_n     = 1'b1;
    res_stb  = 1'b0;
    res_word = '0;
    sck_i    = 1'b0;
    wait_n(3);
    chk(!sdo_oe && !sck_oe && rdy_n, "R1 reset state", {sdo_oe, sck_oe, rdy_n}, 3'b001);
    rst_n = 1'b1;
    wait_n(5);
    chk(!sdo_oe && !sck_oe && rdy_n, "R1 after reset", {sdo_oe, sck_oe, rdy_n}, 3'b001);

    // R9: select low with nothing pending
    begin
      int bad = 0;
      cs_n = 1'b0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (sdo_oe || sck_oe) bad++;
        if (i == 5) cs_n = 1'b1;
        if (i == 7) cs_n = 1'b0;
      end
      chk(bad == 0, "R9 no drive without pending result", bad, 0);
    end

    // R3/R4/R10 sweep in self-clocked mode
    for (int v = 0; v < (1 << W); v++) m_word(W'(v));

    // R4: select falls while a result is pending
    begin
      logic [W-1:0] w = 4'b1101;
      cs_n = 1'b1;
      wait_n(4);
      load(w);
      wait_n(3);
      chk(!sdo_oe, "R9 pending but unselected stays off", sdo_oe, 0);
      cs_n = 1'b0;
      @(negedge clk);
      chk(!sdo_oe, "R4 edge 1 after select", sdo_oe, 0);
      @(negedge clk);
      chk(!sdo_oe, "R4 edge 2 after select", sdo_oe, 0);
      @(negedge clk);
      chk(sdo_oe && sdo == w[W-1], "R4 edge 3 after select", {sdo_oe, sdo}, {1'b1, w[W-1]});
      m_read(w);
    end

    // R2: strobe while pending is ignored
    begin
      logic [W-1:0] w1 = 4'b1001;
      cs_n = 1'b1;
      wait_n(4);
      load(w1);
      load(4'b0110);
      cs_n = 1'b0;
      wait_n(3);
      chk(sdo_oe, "R2 start after ignored strobe", sdo_oe, 1);
      m_read(w1);
    end

    // R8: early release in self-clocked mode
    begin
      logic [W-1:0] w = 4'b1011;
      logic [W-1:0] rx = '0;
      int nb = 0;
      logic prev_sck = 1'b0;
      load(w);
      @(negedge clk);
      @(negedge clk);
      rx = {rx[W-2:0], sdo};
      nb++;
      prev_sck = sck_o;
      cs_n = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!sdo_oe) break;
        if (sck_o) begin
          rx = {rx[W-2:0], sdo};
          nb++;
        end
        prev_sck = sck_o;
      end
      chk(!sdo_oe && !sck_oe && prev_sck && nb == 2, "R8 bit finished before float",
          nb, 2);
      chk(rdy_n == 1'b0, "R8 result still pending", rdy_n, 0);
      cs_n = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (rdy_n) break;
        if (sdo_oe && sck_o) begin
          rx = {rx[W-2:0], sdo};
          nb++;
        end
      end
      chk(nb == W && rx == w, "R8 resume with next unsent bit", int'(rx), int'(w));
    end

    // follower mode sweep
    cs_n = 1'b1;
    wait_n(4);
    clk_self = 1'b0;
    cs_n = 1'b0;
    wait_n(4);
    for (int v = 0; v < (1 << W); v++) s_word(W'(v));

    // R8: early release in follower mode
    begin
      logic [W-1:0] w = 4'b0110;
      logic [W-1:0] rx = '0;
      sck_i = 1'b1;
      wait_n(5);
      load(w);
      wait_n(4);
      sck_i = 1'b0;
      wait_n(5);
      sck_i = 1'b1;
      wait_n(5);
      rx = {rx[W-2:0], sdo};
      cs_n = 1'b1;
      wait_n(5);
      chk(sdo_oe, "R8 follower holds bit until falling edge", sdo_oe, 1);
      sck_i = 1'b0;
      wait_n(5);
      chk(!sdo_oe && !sck_oe && !rdy_n, "R8 follower floats with result pending",
          {sdo_oe, sck_oe, rdy_n}, 3'b000);
      cs_n = 1'b0;
      wait_n(5);
      chk(sdo_oe && sdo == w[W-2], "R8 follower resumes", sdo, w[W-2]);
      for (int k = W - 2; k >= 0; k--) begin
        sck_i = 1'b1;
        wait_n(5);
        rx = {rx[W-2:0], sdo};
        sck_i = 1'b0;
        wait_n(5);
      end
      chk(rx == w && rdy_n && !sdo_oe, "R8 follower full word", int'(rx), int'(w));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule